// File: doc/BRIEF.md
# Core and DMA bus arbiter

This block decides which party owns the internal bus: a single processor core or a DMA engine with four channels. The DMA channels are first reduced to one candidate. Each channel carries a 3-bit bandwidth code, and a smaller code means a more urgent channel. That candidate then competes against the core.

When the core and the DMA side both want the bus, ownership changes hands after each completed transfer. After a DMA transfer the bus goes back to the core, even if another channel is still waiting. A candidate whose code is zero wins over the core whatever the turn. Once a grant is given it stays in place until the transfer-done strobe. The mode field selects the arbitration scheme; this version implements only round-robin, and every encoding behaves that way.

Top module: `bus_arbiter`

## Requirements
- R1: After reset no grant is asserted and the core has first turn: if the core and a channel both request, the core is granted first.
- R2: At most one grant is asserted at any time across core_gnt and the four dma_gnt bits.
- R3: Among requesting channels, the one whose code in dma_prio (channel i at bits [3i+2:3i]) is numerically smallest is chosen, and a tie goes to the lowest channel index.
- R4: While both sides keep requesting, ownership alternates between the core and the DMA side at each transfer-done strobe.
- R5: When a DMA transfer ends and the core is requesting, the core is granted next, even if another channel is still pending.
- R6: A chosen channel whose code is 000 is granted ahead of a requesting core, even when it is the core's turn.
- R7: When only one side requests, it is granted at the next clock edge, whatever the turn.
- R8: A grant stays unchanged, and request changes are ignored, until xfer_done is high at a clock edge.
- R9: With no request pending at a decision point, no grant is asserted.
- R10: Mode values other than 00 give the same round-robin behaviour as 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core requests the bus |
| dma_req | input | 4 | Per-channel DMA request |
| dma_prio | input | 12 | Per-channel 3-bit bandwidth code, channel i at [3i+2:3i] |
| mode | input | 2 | Arbitration scheme select |
| xfer_done | input | 1 | Current transfer finishes this cycle |
| core_gnt | output | 1 | Core owns the bus |
| dma_gnt | output | 4 | One-hot channel grant |

## Verification
The hardest case to reach is the one where a second channel is left waiting. A DMA transfer must end while the core and a different, lower-priority channel are both requesting, and the grant must then return to the core. The stimulus sets this up by granting channel 0 in a tie with channel 1. It drops channel 0's request while that grant is held, then strobes done with the core asking again. A second sequence sets up the zero-code override at the point where the turn belongs to the core.

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int NCH = 4,
  parameter int PW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_req,
  input  logic [NCH-1:0]  dma_req,
  input  logic [NCH*PW-1:0] dma_prio,
  input  logic [1:0]      mode,
  input  logic            xfer_done,
  output logic            core_gnt,
  output logic [NCH-1:0]  dma_gnt
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic          win_any;
  logic [IW-1:0] win_idx;
  logic [PW-1:0] win_code;
  logic          turn_dma;
  logic          alt_en;

  always_comb begin
    win_any  = 1'b0;
    win_idx  = '0;
    win_code = '1;
    for (int i = 0; i < NCH; i++) begin
      if (dma_req[i] && (!win_any || dma_prio[i*PW +: PW] < win_code)) begin
        win_any  = 1'b1;
        win_idx  = IW'(i);
        win_code = dma_prio[i*PW +: PW];
      end
    end
  end

  always_comb begin
    case (mode)
      2'b00:   alt_en = 1'b1;
      default: alt_en = 1'b1;
    endcase
  end

  wire win_max   = win_any && (win_code == '0);
  wire busy      = core_gnt | (|dma_gnt);
  wire decide    = ~busy | xfer_done;
  wire next_turn = (xfer_done && core_gnt)  ? 1'b1 :
                   (xfer_done && |dma_gnt)  ? 1'b0 : turn_dma;
  wire pick_dma  = win_any && (!core_req || win_max || (alt_en && next_turn));
  wire pick_core = core_req && !pick_dma;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_gnt <= 1'b0;
      dma_gnt  <= '0;
      turn_dma <= 1'b0;
    end else begin
      turn_dma <= next_turn;
      if (decide) begin
        core_gnt <= pick_core;
        dma_gnt  <= pick_dma ? (NCH'(1) << win_idx) : '0;
      end
    end
  end
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
  parameter int NCH = 4,
  parameter int PW  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req,
  input logic [NCH-1:0]    dma_req,
  input logic [NCH*PW-1:0] dma_prio,
  input logic              xfer_done,
  input logic              core_gnt,
  input logic [NCH-1:0]    dma_gnt
);
  logic zero_req;
  always_comb begin
    zero_req = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (dma_req[i] && dma_prio[i*PW +: PW] == '0) zero_req = 1'b1;
  end

  wire owned   = core_gnt | (|dma_gnt);
  wire decides = !owned || xfer_done;

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_gnt, dma_gnt})); // R2
  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && !xfer_done) |=> ($stable(core_gnt) && $stable(dma_gnt))); // R8
  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (decides && !core_req && dma_req == '0) |=> (!core_gnt && dma_gnt == '0)); // R9
  AST_CORE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dma_gnt) && xfer_done && core_req && !zero_req) |=> core_gnt); // R5
  AST_MAX_BW: assert property (@(posedge clk) disable iff (!rst_n)
    (decides && zero_req) |=> (|dma_gnt)); // R6
endmodule

bind bus_arbiter bus_arbiter_chk #(.NCH(NCH), .PW(PW)) i_chk (.*);

// File: tb/test_bus_arbiter.sv
module test_bus_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_req = 1'b0;
  logic [3:0]  dma_req = '0;
  logic [11:0] dma_prio = '1;
  logic [1:0]  mode = 2'b00;
  logic        xfer_done = 1'b0;
  logic        core_gnt;
  logic [3:0]  dma_gnt;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          ended = 1'b0;

  always #4 clk = ~clk;

  bus_arbiter i_bus_arbiter (.*);

  // {core_req, dma_req, dma_prio(octal: ch3 ch2 ch1 ch0), done, exp_core, exp_dma}
  localparam int NV = 19;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 4'b0000, 12'o7777, 1'b0, 1'b0, 4'b0000},
    {1'b1, 4'b0011, 12'o7722, 1'b0, 1'b1, 4'b0000},
    {1'b1, 4'b0011, 12'o7722, 1'b0, 1'b1, 4'b0000},
    {1'b1, 4'b0011, 12'o7722, 1'b1, 1'b0, 4'b0001},
    {1'b1, 4'b0010, 12'o7722, 1'b0, 1'b0, 4'b0001},
    {1'b1, 4'b0010, 12'o7722, 1'b1, 1'b1, 4'b0000},
    {1'b0, 4'b0010, 12'o7722, 1'b1, 1'b0, 4'b0010},
    {1'b0, 4'b0000, 12'o7722, 1'b1, 1'b0, 4'b0000},
    {1'b0, 4'b1100, 12'o1477, 1'b0, 1'b0, 4'b1000},
    {1'b1, 4'b1100, 12'o1477, 1'b1, 1'b1, 4'b0000},
    {1'b1, 4'b0100, 12'o7077, 1'b1, 1'b0, 4'b0100},
    {1'b1, 4'b0100, 12'o7077, 1'b1, 1'b0, 4'b0100},
    {1'b1, 4'b0000, 12'o7077, 1'b1, 1'b1, 4'b0000},
    {1'b1, 4'b0000, 12'o7077, 1'b1, 1'b1, 4'b0000},
    {1'b0, 4'b0001, 12'o7771, 1'b0, 1'b1, 4'b0000},
    {1'b0, 4'b0001, 12'o7771, 1'b1, 1'b0, 4'b0001},
    {1'b0, 4'b0000, 12'o7771, 1'b0, 1'b0, 4'b0001},
    {1'b0, 4'b0000, 12'o7771, 1'b1, 1'b0, 4'b0000},
    {1'b0, 4'b0000, 12'o7771, 1'b1, 1'b0, 4'b0000}
  };
  string VTAG [NV] = '{"R9", "R1", "R8", "R4 R3", "R8", "R5", "R7", "R9",
                       "R7 R3", "R4", "R4", "R6", "R5", "R7", "R8", "R7",
                       "R8", "R9", "R9"};

  task automatic check(input string tag, input logic ec, input logic [3:0] ed);
    n_chk++;
    if (core_gnt !== ec || dma_gnt !== ed) begin
      n_bad++;
      $display("FAIL %s: core_gnt=%b dma_gnt=%b expected core_gnt=%b dma_gnt=%b",
               tag, core_gnt, dma_gnt, ec, ed);
    end
  endtask

  task automatic step(input logic c, input logic [3:0] r, input logic [11:0] p, input logic d);
    @(negedge clk);
    core_req = c; dma_req = r; dma_prio = p; xfer_done = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m; core_req = 1'b0; dma_req = '0; xfer_done = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset", 1'b0, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset(2'b00);
    for (int k = 0; k < NV; k++) begin
      step(VEC[k][22], VEC[k][21:18], VEC[k][17:6], VEC[k][5]);
      check(VTAG[k], VEC[k][4], VEC[k][3:0]);
    end
    // R10: a non-zero mode value still alternates, core first
    do_reset(2'b11);
    step(1'b1, 4'b0001, 12'o7771, 1'b0);
    check("R10 core first", 1'b1, 4'b0000);
    step(1'b1, 4'b0001, 12'o7771, 1'b1);
    check("R10 alternation", 1'b0, 4'b0001);
    // R3: smallest code wins, tie resolved to lower index
    do_reset(2'b00);
    step(1'b0, 4'b1111, 12'o6335, 1'b0);
    check("R3 tie lowest index", 1'b0, 4'b0010);
    ended = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!ended) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule